// File: doc/BRIEF.md
# SPI Receive Holding Register with Full and Overrun Status

This block sits between the shift engine of an SPI port and the host bus. Each time the shift engine reports a finished byte, the block either places that byte in a holding register and raises a receive-full flag, or, when the previous byte has not been collected yet, raises an overrun flag and drops the new byte. The unread byte in the holding register is never overwritten.

Software clears the flags with a two-step sequence seen on bus strobes. First it reads status, then it reads data. When the status read happens, the block records which flags were set in two armed bits. The data read that follows clears only the flags that were armed.

The block also merges the receive-full condition, the overrun condition and an externally supplied mode-fault condition into one interrupt request. Receive-full has its own enable. The two error conditions share a single error enable.

Top module: `spi_rx_status`

## Requirements
- R1: A `byte_done` pulse while `rx_full` is 0 loads `byte_data` into `rx_data` and sets `rx_full`, both visible one clock later.
- R2: A `byte_done` pulse while `rx_full` is 1, with no clearing data read in the same cycle, sets `overrun`. In this case `rx_data` keeps the older byte.
- R3: A `stat_rd` while `rx_full` is 1 and `overrun` is 0, followed by a later `data_rd`, clears `rx_full` one clock after the `data_rd`.
- R4: A `stat_rd` while `overrun` is 1, followed by a later `data_rd`, clears `overrun` one clock after the `data_rd`. In this case `rx_full` stays 1 and `rx_data` still shows the older retained byte.
- R5: A `data_rd` with no arming `stat_rd` since the last data read or reset leaves both flags unchanged. A single data read consumes the armed bits.
- R6: A flag that rises after the arming `stat_rd` is not cleared by the following `data_rd`.
- R7: When a `byte_done` lands in the same cycle as a `data_rd` that clears `rx_full`, the clear applies first. The new byte is loaded, `rx_full` ends at 1, and `overrun` is not raised.
- R8: `irq` equals `(rx_int_en & rx_full) | (err_int_en & (overrun | mode_fault))`, combinationally from the current enables.
- R9: A synchronous active-low reset clears `rx_full`, `overrun`, both armed bits and `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_done | input | 1 | One-cycle pulse when the shift engine completes a byte |
| byte_data | input | DATA_W | Completed byte, valid with `byte_done` |
| stat_rd | input | 1 | One-cycle strobe for a status register read |
| data_rd | input | 1 | One-cycle strobe for a data register read |
| rx_int_en | input | 1 | Receiver interrupt enable |
| err_int_en | input | 1 | Shared error interrupt enable |
| mode_fault | input | 1 | Mode-fault flag from the port's control logic |
| rx_data | output | DATA_W | Holding register contents |
| rx_full | output | 1 | Receive-full flag |
| overrun | output | 1 | Overrun flag |
| irq | output | 1 | Combined receive/error interrupt request |

## Verification
The assertions take the strobes `byte_done`, `stat_rd` and `data_rd` to be synchronous, single-cycle and free of X after reset. They also take `mode_fault` and the enables to be driven levels. The stimulus changes every input one time unit after a rising edge and holds it for exactly one cycle. It never asserts `stat_rd` and `data_rd` in the same cycle, so the ordering cases stay unambiguous. Each vector is checked after the next rising edge, and the expected flags are worked out from the requirements.

// File: rtl/spi_rx_pkg.sv
// Package: shared types for the SPI receive status block.
// Assumes nothing beyond a single clock domain.
package spi_rx_pkg;
    typedef struct packed {
        logic full;
        logic ovr;
    } rx_flags_t;
endpackage

// File: rtl/spi_rx_hold.sv
// Module: holding register for received bytes.
// Loads din when load is high and otherwise retains its contents.
// Assumes load is a single-cycle qualified pulse from the flag controller.
module spi_rx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] hold_q;

    // Capture the byte on load, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    hold_q <= '0;
        else if (load) hold_q <= din;
    end

    assign dout = hold_q;

    // R1: a load makes the new byte visible on the next cycle.
    p_load_visible_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> dout == $past(din));

    // R2: without a load the contents are retained.
    p_retain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dout));
endmodule

// File: rtl/spi_rx_flags.sv
// Module: receive-full and overrun flag controller.
// Keeps armed bits captured on status reads. A data read clears only the
// armed flags, and the clear is applied before a same-cycle byte completion.
// Assumes all strobes are single-cycle and synchronous to clk.
module spi_rx_flags
    import spi_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      byte_done,
    input  logic      stat_rd,
    input  logic      data_rd,
    output logic      load,
    output rx_flags_t flags
);
    rx_flags_t flags_q, flags_d;
    rx_flags_t armed_q, armed_d;
    rx_flags_t after_clr;

    // Apply the armed clear first, then the byte completion.
    always_comb begin
        after_clr.full = flags_q.full & ~(data_rd & armed_q.full);
        after_clr.ovr  = flags_q.ovr  & ~(data_rd & armed_q.ovr);
        flags_d        = after_clr;
        load           = 1'b0;
        if (byte_done) begin
            if (after_clr.full) begin
                flags_d.ovr = 1'b1;
            end else begin
                flags_d.full = 1'b1;
                load         = 1'b1;
            end
        end
    end

    // Arm on status read; a data read consumes the armed bits.
    always_comb begin
        armed_d = armed_q;
        if (stat_rd) begin
            armed_d.full = flags_q.full & ~flags_q.ovr;
            armed_d.ovr  = flags_q.ovr;
        end else if (data_rd) begin
            armed_d = '0;
        end
    end

    // Flag and armed-bit state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            armed_q <= '0;
        end else begin
            flags_q <= flags_d;
            armed_q <= armed_d;
        end
    end

    assign flags = flags_q;

    // R5: receive-full that is not armed survives any data read.
    p_full_unarmed_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q.full && !armed_q.full |=> flags_q.full);

    // R2: overrun is sticky until an armed data read.
    p_ovr_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q.ovr && !(data_rd && armed_q.ovr) |=> flags_q.ovr);

    // R7: clear-then-complete in one cycle ends full, without overrun.
    p_clear_then_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd && armed_q.full && byte_done && !flags_q.ovr
        |=> flags_q.full && !flags_q.ovr);

    // R5: a data read with no status read in the same cycle leaves nothing armed.
    p_armed_consumed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd && !stat_rd |=> armed_q == '0);
endmodule

// File: rtl/spi_rx_irq.sv
// Module: merges the receive and error conditions into one request line.
// Assumes the enables and mode_fault are level signals.
module spi_rx_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic full,
    input  logic ovr,
    input  logic mode_fault,
    input  logic rx_en,
    input  logic err_en,
    output logic irq
);
    // Combine the enabled sources.
    always_comb begin
        irq = (rx_en & full) | (err_en & (ovr | mode_fault));
    end

    // R8: with both enables low the request stays quiet.
    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en && !err_en |-> !irq);

    // R8: an enabled error source always requests.
    p_irq_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_en && (ovr || mode_fault) |-> irq);
endmodule

// File: rtl/spi_rx_status.sv
// Module: top of the SPI receive status block.
// Ties together the flag controller, the holding register and the interrupt merge.
// Assumes the shift engine pulses byte_done for one cycle per completed byte.
module spi_rx_status
    import spi_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              rx_int_en,
    input  logic              err_int_en,
    input  logic              mode_fault,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              overrun,
    output logic              irq
);
    logic      load;
    rx_flags_t flags;

    spi_rx_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_done (byte_done),
        .stat_rd   (stat_rd),
        .data_rd   (data_rd),
        .load      (load),
        .flags     (flags)
    );

    spi_rx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .din   (byte_data),
        .dout  (rx_data)
    );

    spi_rx_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .full       (flags.full),
        .ovr        (flags.ovr),
        .mode_fault (mode_fault),
        .rx_en      (rx_int_en),
        .err_en     (err_int_en),
        .irq        (irq)
    );

    assign rx_full = flags.full;
    assign overrun = flags.ovr;

    // R2: a byte arriving while full, without a data read, keeps the old byte and sets overrun.
    p_overrun_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done && rx_full && !data_rd |=> overrun && $stable(rx_data));

    // R1: a byte arriving while empty is captured.
    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done && !rx_full |=> rx_full && rx_data == $past(byte_data));
endmodule

// File: tb/spi_rx_status_tb.sv
module spi_rx_status_tb;
    localparam int W = 8;

    typedef struct packed {
        logic         bd;
        logic [W-1:0] dat;
        logic         srd;
        logic         drd;
        logic         rxen;
        logic         erren;
        logic         mf;
        logic         efull;
        logic         eovr;
        logic [W-1:0] edat;
        logic         eirq;
        logic [3:0]   req;
    } vec_t;

    localparam int NV = 18;
    // bd dat srd drd rxen erren mf | full ovr data irq | req
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA5, 1'b0, 4'd1}, // R1 load
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA5, 1'b0, 4'd3}, // R3 arm
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 4'd3}, // R3 clear
        '{1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h3C, 1'b0, 4'd1}, // R1 second byte
        '{1'b1, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 1'b0, 4'd2}, // R2 drop
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 1'b0, 4'd4}, // R4 arm ovr
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h3C, 1'b0, 4'd4}, // R4 clear ovr only
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h3C, 1'b0, 4'd5}, // R5 unarmed read
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h3C, 1'b0, 4'd6}, // R6 arm full
        '{1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 1'b0, 4'd6}, // R6 late overrun
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C, 1'b0, 4'd6}, // R6 ovr kept
        '{1'b1, 8'h22, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h22, 1'b1, 4'd8}, // R8 rx irq
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h22, 1'b0, 4'd8}, // R8 masked
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h22, 1'b0, 4'd4}, // R4 ovr cleared
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h22, 1'b0, 4'd7}, // R7 arm
        '{1'b1, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h5A, 1'b0, 4'd7}, // R7 same cycle
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h5A, 1'b1, 4'd8}, // R8 mode fault
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h5A, 1'b1, 4'd8}  // R8 rx only
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         byte_done, stat_rd, data_rd, rx_int_en, err_int_en, mode_fault;
    logic [W-1:0] byte_data, rx_data;
    logic         rx_full, overrun, irq;
    int           checks = 0;
    int           fails = 0;

    always #5 clk = ~clk;

    spi_rx_status #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_data(byte_data),
        .stat_rd(stat_rd), .data_rd(data_rd), .rx_int_en(rx_int_en),
        .err_int_en(err_int_en), .mode_fault(mode_fault), .rx_data(rx_data),
        .rx_full(rx_full), .overrun(overrun), .irq(irq)
    );

    task automatic idle();
        byte_done = 0; byte_data = '0; stat_rd = 0; data_rd = 0;
        rx_int_en = 0; err_int_en = 0; mode_fault = 0;
    endtask

    task automatic chk(input string tag, input logic [W+2:0] act, input logic [W+2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual={full,ovr,irq,data}=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        tick(); tick();
        // R9: reset state
        chk("R9 reset", {rx_full, overrun, irq, rx_data}, '0);
        rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            byte_done  = VECS[i].bd;   byte_data  = VECS[i].dat;
            stat_rd    = VECS[i].srd;  data_rd    = VECS[i].drd;
            rx_int_en  = VECS[i].rxen; err_int_en = VECS[i].erren;
            mode_fault = VECS[i].mf;
            tick();
            chk($sformatf("R%0d vec%0d", VECS[i].req, i),
                {rx_full, overrun, irq, rx_data},
                {VECS[i].efull, VECS[i].eovr, VECS[i].eirq, VECS[i].edat});
        end

        // R9: reset mid-run clears flags, data and armed bits
        idle(); stat_rd = 1; tick();
        idle(); rst_n = 0; tick();
        chk("R9 midrun", {rx_full, overrun, irq, rx_data}, '0);
        rst_n = 1;
        byte_done = 1; byte_data = 8'hC3; tick();
        idle(); data_rd = 1; tick();
        idle();
        chk("R9 armed cleared", {rx_full, overrun, irq, rx_data}, {1'b1, 1'b0, 1'b0, 8'hC3});

        // R5: one status read arms one data read only
        stat_rd = 1; tick(); idle();
        byte_done = 1; byte_data = 8'h01; tick(); idle();   // R2 overrun, data stays C3
        chk("R2 directed", {rx_full, overrun, irq, rx_data}, {1'b1, 1'b1, 1'b0, 8'hC3});
        data_rd = 1; tick(); idle();                        // clears full only
        data_rd = 1; tick(); idle();                        // nothing armed now
        chk("R5 consumed", {rx_full, overrun, irq, rx_data}, {1'b0, 1'b1, 1'b0, 8'hC3});

        // R8: error enable with overrun alone
        err_int_en = 1; #1;
        chk("R8 ovr irq", {rx_full, overrun, irq, rx_data}, {1'b0, 1'b1, 1'b1, 8'hC3});
        idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule